// File: doc/BRIEF.md
# Byte-Lane SRAM Storage and Read Datapath

This block is the storage array and data path of a small synchronous SRAM. A sequencer outside the block supplies one word address per clock together with a select flag and the write controls. On each rising edge a selected cycle becomes either a write or a read. A write stores the chosen 9-bit lanes of the input word. A global-write strobe overrides the per-lane controls and stores every lane. A selected cycle that asks for no lane write is a read.

Read data returns in one of two timings, chosen by a strap pin. In flow-through timing the word is driven in the cycle right after the command edge, straight from the array. In pipelined timing it passes through an output register and appears one edge later. A deselect travels down the same pipeline as a read. The data driver therefore stays on for data already in flight and turns off only when the deselect reaches the output stage.

The shared bidirectional data bus is modelled as an input bus, an output bus and a drive flag. The output-enable and sleep inputs gate the drive flag without waiting for a clock. While sleep is high the pipeline and the array hold their state and no command is taken.

Top module: `sbw_ram_path`

## Requirements
- R1: With `pipe_mode_i` low (flow-through), a read sampled at edge k drives the word at that address from just after edge k until edge k+1. Reads issued every cycle yield one word per cycle.
- R2: With `pipe_mode_i` high (pipelined), a read sampled at edge k drives the word from just after edge k+1 until edge k+2, captured in the output register at edge k+1. Reads issued every cycle yield one word per cycle.
- R3: A deselect (`sel_i` low) follows the same latency as a read. The drive flag for data already in flight stays on, and it falls only when the deselect reaches the output stage: after edge k in flow-through timing, after edge k+1 in pipelined timing.
- R4: A byte write happens when `sel_i` is high, `gw_ni` is high, `bw_ni` is low and at least one bit of `lane_we_ni` is low. Lane i is bits [9i+8:9i] and is written only if `lane_we_ni[i]` is low. Other lanes keep their contents.
- R5: With `sel_i` high and `gw_ni` low, all four lanes are written, whatever the values of `bw_ni` and `lane_we_ni`.
- R6: With `gw_ni` high, a selected cycle where `bw_ni` is high, or where all of `lane_we_ni` are high, writes nothing and is treated as a read.
- R7: `oe_ni` high forces `drive_o` low at once, with no clock edge needed, and does not disturb the data in flight.
- R8: While `sleep_i` is high, `drive_o` is low at once, no command is accepted and the array and pipeline keep their contents. The first edge after `sleep_i` falls resumes operation from the held state.
- R9: `drive_o` is low in any cycle whose current port inputs form a write command.
- R10: While reset is active and after it is released, `drive_o` stays low until a read reaches the output stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Rising-edge clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sel_i | input | 1 | Cycle selected (high) or deselect (low) |
| addr_i | input | 4 | Word address from the sequencer |
| wdata_i | input | 36 | Write data, four 9-bit lanes |
| lane_we_ni | input | 4 | Per-lane write enables, active low |
| bw_ni | input | 1 | Byte-write enable, active low |
| gw_ni | input | 1 | Global write, active low |
| pipe_mode_i | input | 1 | 1 selects pipelined timing, 0 selects flow-through |
| oe_ni | input | 1 | Asynchronous output enable, active low |
| sleep_i | input | 1 | Asynchronous sleep, active high |
| rdata_o | output | 36 | Read data toward the bus |
| drive_o | output | 1 | Bus driver enable for rdata_o |

## Verification
The array is first filled by global writes that carry assorted values on the byte-write controls, which shows that the global strobe ignores them. Back-to-back reads are run in both timing modes and compared against a behavioural model every cycle. This separates the one-edge and two-edge latencies, and interleaved deselects show whether the driver turns off at the read depth or one cycle early. Byte writes with sparse lane patterns, followed by read-back, show which lanes changed. Cycles that look like writes but lack a lane or the byte-write enable check that they are decoded as reads. Output-enable toggling, alternating reads and writes, and a sleep window with writes presented during it check the asynchronous gating, the write-cycle turn-off and the state kept across sleep.

// File: rtl/sbw_pkg.sv
package sbw_pkg;
  typedef enum logic [1:0] {
    CMD_IDLE  = 2'd0,
    CMD_READ  = 2'd1,
    CMD_WRITE = 2'd2
  } sbw_cmd_e;
endpackage

// File: rtl/sbw_decode.sv
module sbw_decode
  import sbw_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic             sel_i,
  input  logic [LANES-1:0] lane_we_ni,
  input  logic             bw_ni,
  input  logic             gw_ni,
  output sbw_cmd_e         cmd_o,
  output logic [LANES-1:0] mask_o
);
  logic any_lane;

  always_comb begin
    any_lane = ~&lane_we_ni;
    mask_o   = '0;
    cmd_o    = CMD_IDLE;
    if (sel_i) begin
      if (!gw_ni) begin
        // global strobe overrides lane controls
        mask_o = '1;
        cmd_o  = CMD_WRITE;
      end else if (!bw_ni && any_lane) begin
        mask_o = ~lane_we_ni;
        cmd_o  = CMD_WRITE;
      end else begin
        cmd_o  = CMD_READ;
      end
    end
  end
endmodule

// File: rtl/sbw_lane_bank.sv
module sbw_lane_bank #(
  parameter int AW = 4,
  parameter int LW = 9
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [LW-1:0] wd_i,
  input  logic [AW-1:0] raddr_i,
  output logic [LW-1:0] rd_o
);
  localparam int DEPTH = 1 << AW;

  logic [LW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) begin
      mem_q[waddr_i] <= wd_i;
    end
  end

  assign rd_o = mem_q[raddr_i];
endmodule

// File: rtl/sbw_read_pipe.sv
module sbw_read_pipe #(
  parameter int AW = 4,
  parameter int DW = 36
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          adv_i,
  input  logic          rd_req_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] mem_q_i,
  input  logic          pipe_mode_i,
  output logic [AW-1:0] s1_addr_o,
  output logic [DW-1:0] q_o,
  output logic          vld_o
);
  logic          s1_v_q, s1_v_d;
  logic [AW-1:0] s1_a_q, s1_a_d;
  logic          s2_v_q, s2_v_d;
  logic [DW-1:0] s2_d_q, s2_d_d;

  always_comb begin
    s1_v_d = s1_v_q;
    s1_a_d = s1_a_q;
    s2_v_d = s2_v_q;
    s2_d_d = s2_d_q;
    if (adv_i) begin
      s1_v_d = rd_req_i;
      s1_a_d = addr_i;
      s2_v_d = s1_v_q;
      s2_d_d = mem_q_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_v_q <= 1'b0;
      s2_v_q <= 1'b0;
    end else begin
      s1_v_q <= s1_v_d;
      s2_v_q <= s2_v_d;
    end
  end

  always_ff @(posedge clk_i) begin
    s1_a_q <= s1_a_d;
    s2_d_q <= s2_d_d;
  end

  assign s1_addr_o = s1_a_q;
  assign q_o       = pipe_mode_i ? s2_d_q : mem_q_i;
  assign vld_o     = pipe_mode_i ? s2_v_q : s1_v_q;
endmodule

// File: rtl/sbw_ram_path.sv
module sbw_ram_path
  import sbw_pkg::*;
#(
  parameter int AW    = 4,
  parameter int LANES = 4,
  parameter int LW    = 9
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                sel_i,
  input  logic [AW-1:0]       addr_i,
  input  logic [LANES*LW-1:0] wdata_i,
  input  logic [LANES-1:0]    lane_we_ni,
  input  logic                bw_ni,
  input  logic                gw_ni,
  input  logic                pipe_mode_i,
  input  logic                oe_ni,
  input  logic                sleep_i,
  output logic [LANES*LW-1:0] rdata_o,
  output logic                drive_o
);
  localparam int DW = LANES * LW;

  logic          rst_meta_q, rst_sync_q;
  sbw_cmd_e      cmd;
  logic [LANES-1:0] mask;
  logic          adv;
  logic          wr_go;
  logic [AW-1:0] s1_addr;
  logic [DW-1:0] mem_q;
  logic          vld;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  sbw_decode #(.LANES(LANES)) u_decode (
    .sel_i      (sel_i),
    .lane_we_ni (lane_we_ni),
    .bw_ni      (bw_ni),
    .gw_ni      (gw_ni),
    .cmd_o      (cmd),
    .mask_o     (mask)
  );

  assign adv   = !sleep_i;
  assign wr_go = adv && (cmd == CMD_WRITE);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    sbw_lane_bank #(.AW(AW), .LW(LW)) u_bank (
      .clk_i   (clk_i),
      .we_i    (wr_go && mask[g]),
      .waddr_i (addr_i),
      .wd_i    (wdata_i[g*LW +: LW]),
      .raddr_i (s1_addr),
      .rd_o    (mem_q[g*LW +: LW])
    );
  end

  sbw_read_pipe #(.AW(AW), .DW(DW)) u_pipe (
    .clk_i       (clk_i),
    .rst_ni      (rst_sync_q),
    .adv_i       (adv),
    .rd_req_i    (cmd == CMD_READ),
    .addr_i      (addr_i),
    .mem_q_i     (mem_q),
    .pipe_mode_i (pipe_mode_i),
    .s1_addr_o   (s1_addr),
    .q_o         (rdata_o),
    .vld_o       (vld)
  );

  assign drive_o = !oe_ni && !sleep_i && vld && (cmd != CMD_WRITE);
endmodule

// File: rtl/sbw_ram_path_chk.sv
module sbw_ram_path_chk #(
  parameter int LANES = 4,
  parameter int DW    = 36
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             sel_i,
  input logic [LANES-1:0] lane_we_ni,
  input logic             bw_ni,
  input logic             gw_ni,
  input logic             pipe_mode_i,
  input logic             oe_ni,
  input logic             sleep_i,
  input logic [DW-1:0]    rdata_o,
  input logic             drive_o
);
  logic wr_port;
  logic rd_port;
  assign wr_port = sel_i && (!gw_ni || (!bw_ni && (lane_we_ni != '1)));
  assign rd_port = sel_i && !wr_port;

  AST_OE_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_ni |-> !drive_o); // R7

  AST_SLEEP_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_i |-> !drive_o); // R8

  AST_SLEEP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sleep_i && $past(sleep_i) && pipe_mode_i && $past(pipe_mode_i)) |-> $stable(rdata_o)); // R8

  AST_WRITE_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_port |-> !drive_o); // R9

  AST_FLOW_READ_ON: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rd_port) && !$past(sleep_i) && !pipe_mode_i && !oe_ni && !sleep_i && !wr_port)
      |-> drive_o); // R1

  AST_PIPE_DESEL_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pipe_mode_i && !$past(sel_i, 2) && !$past(sleep_i, 2) && !$past(sleep_i)) |-> !drive_o); // R3
endmodule

bind sbw_ram_path sbw_ram_path_chk #(.LANES(LANES), .DW(LANES*LW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .sel_i       (sel_i),
  .lane_we_ni  (lane_we_ni),
  .bw_ni       (bw_ni),
  .gw_ni       (gw_ni),
  .pipe_mode_i (pipe_mode_i),
  .oe_ni       (oe_ni),
  .sleep_i     (sleep_i),
  .rdata_o     (rdata_o),
  .drive_o     (drive_o)
);

// File: tb/sbw_ram_path_tb.sv
module sbw_ram_path_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel = 1'b0;
  logic [3:0]  addr = '0;
  logic [35:0] wdata = '0;
  logic [3:0]  lane_n = 4'hF;
  logic        bw_n = 1'b1;
  logic        gw_n = 1'b1;
  logic        pipe = 1'b1;
  logic        oe_n = 1'b0;
  logic        sleep = 1'b0;
  logic [35:0] rdata;
  logic        drive;

  int    n_run  = 0;
  int    n_fail = 0;
  string tag    = "R10";

  always #2.5 clk = ~clk;

  sbw_ram_path u_dut (
    .clk_i(clk), .rst_ni(rst_n), .sel_i(sel), .addr_i(addr), .wdata_i(wdata),
    .lane_we_ni(lane_n), .bw_ni(bw_n), .gw_ni(gw_n), .pipe_mode_i(pipe),
    .oe_ni(oe_n), .sleep_i(sleep), .rdata_o(rdata), .drive_o(drive)
  );

  // behavioural reference model
  logic [35:0] m_mem [16];
  bit          mv1 = 0, mv2 = 0;
  logic [3:0]  ma1;
  logic [35:0] md2;
  bit          mr1 = 0, mr2 = 0;
  bit          w_old;

  function automatic bit is_wr(logic s, logic g, logic b, logic [3:0] l);
    return s && (!g || (!b && l != 4'hF));
  endfunction

  always @(posedge clk) begin
    if (!rst_n || !mr2) begin
      mv1 = 0;
      mv2 = 0;
    end else if (!sleep) begin
      w_old = is_wr(sel, gw_n, bw_n, lane_n);
      md2 = m_mem[ma1];
      mv2 = mv1;
      mv1 = sel && !w_old;
      ma1 = addr;
      if (w_old)
        for (int l = 0; l < 4; l++)
          if (!gw_n || !lane_n[l]) m_mem[addr][l*9 +: 9] = wdata[l*9 +: 9];
    end
    mr2 = mr1;
    mr1 = rst_n;
  end

  task automatic chk(bit ok, string req, logic [35:0] act, logic [35:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    bit          ev, ed;
    logic [35:0] eq;
    ev = pipe ? mv2 : mv1;
    eq = pipe ? md2 : m_mem[ma1];
    ed = !oe_n && !sleep && ev && !is_wr(sel, gw_n, bw_n, lane_n);
    chk(drive === ed, tag, {35'd0, drive}, {35'd0, ed});
    if (ed) chk(rdata === eq, tag, rdata, eq);
  end

  task automatic op(logic s, logic [3:0] a, logic [35:0] d, logic [3:0] l, logic b, logic g);
    @(posedge clk);
    #1;
    sel = s; addr = a; wdata = d; lane_n = l; bw_n = b; gw_n = g;
  endtask

  task automatic rd(logic [3:0] a);
    op(1'b1, a, 36'h0, 4'hF, 1'b1, 1'b1);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) op(1'b0, 4'h0, 36'h0, 4'hF, 1'b1, 1'b1);
  endtask

  function automatic logic [35:0] pat(int a);
    return {9'(a * 7 + 1), 9'(a * 3 + 5), 9'(a + 100), 9'(a ^ 9'h155)};
  endfunction

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    idle(3);

    tag = "R5";   // global writes with noisy byte controls
    for (int a = 0; a < 16; a++)
      op(1'b1, 4'(a), pat(a), (a % 2 == 1) ? 4'h0 : 4'hF, (a % 3 == 0) ? 1'b0 : 1'b1, 1'b0);
    idle(2);

    tag = "R2";
    pipe = 1'b1;
    for (int a = 0; a < 16; a++) rd(4'(a));
    tag = "R3";
    idle(1); rd(4'd2); idle(1); rd(4'd5); idle(3);

    tag = "R1";
    pipe = 1'b0;
    idle(1);
    for (int a = 15; a >= 0; a--) rd(4'(a));
    tag = "R3";
    idle(1); rd(4'd9); idle(1); rd(4'd1); idle(2);

    tag = "R4";
    pipe = 1'b1;
    op(1'b1, 4'd3, 36'hA_BCDE_F012, 4'b1110, 1'b0, 1'b1);
    op(1'b1, 4'd4, 36'h1_2345_6789, 4'b0101, 1'b0, 1'b1);
    op(1'b1, 4'd5, 36'hF_0F0F_0F0F, 4'b0000, 1'b0, 1'b1);
    rd(4'd3); rd(4'd4); rd(4'd5); idle(3);

    tag = "R6";
    op(1'b1, 4'd6, 36'hD_EAD0_BEEF, 4'h0, 1'b1, 1'b1);
    op(1'b1, 4'd7, 36'hC_AFE0_1234, 4'hF, 1'b0, 1'b1);
    rd(4'd6); rd(4'd7); idle(3);

    tag = "R9";
    for (int m = 0; m < 2; m++) begin
      pipe = (m == 0);
      idle(1);
      rd(4'd8);
      op(1'b1, 4'd9, 36'h5_5555_AAAA, 4'hF, 1'b1, 1'b0);
      rd(4'd9);
      op(1'b1, 4'd8, 36'h7_7777_7777, 4'b1011, 1'b0, 1'b1);
      rd(4'd8);
      idle(3);
    end

    tag = "R7";
    for (int m = 0; m < 2; m++) begin
      pipe = (m == 0);
      for (int a = 0; a < 6; a++) begin
        rd(4'(a));
        oe_n = a[0];
      end
      idle(1); oe_n = 1'b0;
      idle(2);
    end

    tag = "R8";
    for (int m = 0; m < 2; m++) begin
      pipe = (m == 0);
      rd(4'd10); rd(4'd11);
      sleep = 1'b1;
      op(1'b1, 4'd10, 36'h0_0000_0001, 4'hF, 1'b1, 1'b0);
      rd(4'd12);
      op(1'b1, 4'd11, 36'h0_0000_0002, 4'h0, 1'b0, 1'b1);
      idle(1);
      sleep = 1'b0;
      rd(4'd10); rd(4'd11); idle(3);
    end

    tag = "R10";
    #1 rst_n = 1'b0;
    idle(2);
    #1 rst_n = 1'b1;
    idle(4);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule